// File: doc/BRIEF.md
# Self-Calibration Start and Busy Sequencer

This block governs when an on-demand calibration run of a data converter begins and ends. A raw start request arrives from outside the clock domain, passes through a two-stage synchronizer, and must then be seen high on a minimum number of consecutive clock edges before it counts. An accepted request starts a run of a fixed, parameterised number of clocks. During the run a ready flag is held low to block conversion, an enable output is held high, and a periodic step strobe paces the calibration datapath. When the run ends, the ready flag rises again and a one-cycle done pulse marks the boundary.

Requests that arrive while a run is in progress are dropped. A request that is still high when a run ends does not start a second run. The request line must first be seen low, and then a fresh qualified pulse is needed. The mismatch measurement itself is not part of this block; the run counter stands in for its duration.

Top module: `selfcal_sequencer`

## Requirements
- R1: While reset is asserted, and directly after it, conv_ok_o is 1 and cal_active_o, cal_step_o and cal_done_o are 0. An asynchronous reset in the middle of a run returns these outputs to the same values at once.
- R2: A request is accepted only if cal_req_i is sampled high on at least MIN_WIDTH consecutive rising edges (default 4). A pulse sampled high on fewer edges leaves every output unchanged.
- R3: conv_ok_o falls exactly on the fifth rising edge after the first edge that samples an accepted request high: two synchronizer stages, the width count, and one registered start.
- R4: Once it has fallen, conv_ok_o stays low for exactly RUN_CYCLES clocks (default 17400) and then returns high.
- R5: cal_done_o pulses high for exactly one clock, in the first cycle in which conv_ok_o is high again after a run. It is 0 at all other times.
- R6: cal_active_o is always the inverse of conv_ok_o.
- R7: A request pulse that begins and ends while a run is active has no effect. The run length is unchanged, there is exactly one done pulse, and no further run follows.
- R8: A request still held high when a run ends does not start another run. After cal_req_i has been sampled low, a new qualified pulse starts a new run with the R3 timing.
- R9: cal_step_o pulses for one clock on the last cycle of each group of STEP_CYCLES run cycles, counted from the first run cycle. A run therefore gives floor(RUN_CYCLES/STEP_CYCLES) pulses, and cal_step_o is 0 outside a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cal_req_i | input | 1 | Raw start request, asynchronous to clk_i |
| conv_ok_o | output | 1 | High when conversion is allowed, low while calibration runs |
| cal_active_o | output | 1 | Enable for the calibration datapath during a run |
| cal_step_o | output | 1 | One-cycle step strobe every STEP_CYCLES run cycles |
| cal_done_o | output | 1 | One-cycle pulse when a run finishes |

## Verification
A width counter that is off by one shows up within a few clocks of the request. Either conv_ok_o falls one edge early or late, or a 3-sample or 4-sample pulse lands on the wrong side of acceptance. A run counter with a bad reload or bad terminal value is seen only at the end of the run, as a low period of the wrong length or a misplaced done pulse. A stuck or missing re-arm flag appears after the run, as a second run that nobody requested, or as a run that fails to start after the line has been seen low. A step counter that drifts is exposed by strobes that fall off the group boundary or that appear outside the run.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [0:0] {
        CAL_IDLE = 1'b0,
        CAL_RUN  = 1'b1
    } cal_phase_e;

    localparam int unsigned CAL_SYNC_STAGES = 2;

endpackage

// File: rtl/cal_req_sync.sv
module cal_req_sync #(
    parameter int unsigned STAGES = cal_seq_pkg::CAL_SYNC_STAGES
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_async_i,
    output logic req_sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = req_async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], req_async_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign req_sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cal_width_qual.sv
module cal_width_qual #(
    parameter int unsigned MIN_WIDTH = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_sync_i,
    input  logic busy_i,
    output logic accept_o
);
    localparam int unsigned HW = $clog2(MIN_WIDTH + 1);
    localparam logic [HW-1:0] HI_LAST = HW'(MIN_WIDTH - 1);

    typedef struct packed {
        logic          armed;
        logic [HW-1:0] hi_cnt;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        accept_o = st_q.armed && req_sync_i && (st_q.hi_cnt == HI_LAST) && !busy_i;

        if (!req_sync_i)                st_d.hi_cnt = '0;
        else if (st_q.hi_cnt != HI_LAST) st_d.hi_cnt = st_q.hi_cnt + 1'b1;

        if (busy_i)           st_d.armed = 1'b0;
        else if (!req_sync_i) st_d.armed = 1'b1;
        else if (accept_o)    st_d.armed = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    AST_ACCEPT_ON_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |-> $past(req_sync_i)); // R2
    AST_NO_RETRIGGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |-> !$past(busy_i)); // R8
endmodule

// File: rtl/cal_run_timer.sv
module cal_run_timer
    import cal_seq_pkg::*;
#(
    parameter int unsigned RUN_CYCLES  = 17400,
    parameter int unsigned STEP_CYCLES = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o,
    output logic step_o,
    output logic done_o
);
    localparam int unsigned RW = $clog2(RUN_CYCLES);
    localparam int unsigned SW = $clog2(STEP_CYCLES);
    localparam logic [RW-1:0] RUN_LAST  = RW'(RUN_CYCLES - 1);
    localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CYCLES - 1);

    typedef struct packed {
        cal_phase_e    phase;
        logic [RW-1:0] run_cnt;
        logic [SW-1:0] step_cnt;
        logic          done;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            CAL_IDLE: begin
                if (start_i) begin
                    st_d.phase    = CAL_RUN;
                    st_d.run_cnt  = RUN_LAST;
                    st_d.step_cnt = '0;
                end
            end
            CAL_RUN: begin
                if (st_q.run_cnt == '0) begin
                    st_d.phase    = CAL_IDLE;
                    st_d.done     = 1'b1;
                    st_d.step_cnt = '0;
                end else begin
                    st_d.run_cnt  = st_q.run_cnt - 1'b1;
                    st_d.step_cnt = (st_q.step_cnt == STEP_LAST) ? '0 : st_q.step_cnt + 1'b1;
                end
            end
            default: st_d.phase = CAL_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{phase: CAL_IDLE, run_cnt: '0, step_cnt: '0, done: 1'b0};
        else         st_q <= st_d;
    end

    assign busy_o = (st_q.phase == CAL_RUN);
    assign step_o = busy_o && (st_q.step_cnt == STEP_LAST);
    assign done_o = st_q.done;

    AST_RUN_NOT_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && st_q.run_cnt != '0) |=> busy_o); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R5
    AST_DONE_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o))); // R5
endmodule

// File: rtl/selfcal_sequencer.sv
module selfcal_sequencer #(
    parameter int unsigned MIN_WIDTH   = 4,
    parameter int unsigned RUN_CYCLES  = 17400,
    parameter int unsigned STEP_CYCLES = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cal_req_i,
    output logic conv_ok_o,
    output logic cal_active_o,
    output logic cal_step_o,
    output logic cal_done_o
);
    logic req_sync;
    logic accept;
    logic busy;

    cal_req_sync #(
        .STAGES(cal_seq_pkg::CAL_SYNC_STAGES)
    ) u_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_async_i(cal_req_i),
        .req_sync_o (req_sync)
    );

    cal_width_qual #(
        .MIN_WIDTH(MIN_WIDTH)
    ) u_qual (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_sync_i(req_sync),
        .busy_i    (busy),
        .accept_o  (accept)
    );

    cal_run_timer #(
        .RUN_CYCLES (RUN_CYCLES),
        .STEP_CYCLES(STEP_CYCLES)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(accept),
        .busy_o (busy),
        .step_o (cal_step_o),
        .done_o (cal_done_o)
    );

    assign conv_ok_o    = !busy;
    assign cal_active_o = busy;

    AST_START_FROM_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy) |-> $past(accept)); // R3
    AST_STEP_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cal_step_o |-> !conv_ok_o); // R9
    AST_DONE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cal_done_o |-> conv_ok_o); // R5
endmodule

// File: tb/sim_selfcal_sequencer.sv
module sim_selfcal_sequencer;
    localparam int MINW = 4;
    localparam int RUN  = 40;
    localparam int STEP = 8;
    localparam int FALL = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic ok, act, stp, dn;
    int vectors = 0;
    int miss = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    selfcal_sequencer #(.MIN_WIDTH(MINW), .RUN_CYCLES(RUN), .STEP_CYCLES(STEP)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .cal_req_i(req),
        .conv_ok_o(ok), .cal_active_o(act), .cal_step_o(stp), .cal_done_o(dn)
    );

    task automatic chk(input string tag, input int a, input int e);
        vectors++;
        if (a != e) begin
            miss++;
            $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
        end
    endtask

    // Caller is at a negedge. Request is high for the first w sampling edges,
    // and again for edges p2s .. p2s+p2l-1.
    task automatic observe(input int w, input int p2s, input int p2l, input int ncyc,
                           output int fall_c, output int rise_c, output int falls,
                           output int done_n, output int done_c,
                           output int step_n, output int step_bad, output int inv_bad);
        logic prev = 1'b1;
        fall_c = 0; rise_c = 0; falls = 0; done_n = 0; done_c = 0;
        step_n = 0; step_bad = 0; inv_bad = 0;
        req = (w > 0);
        for (int c = 1; c <= ncyc; c++) begin
            @(negedge clk);
            if (prev && !ok) begin falls++; if (fall_c == 0) fall_c = c; end
            if (!prev && ok && rise_c == 0) rise_c = c;
            if (dn) begin done_n++; if (done_c == 0) done_c = c; end
            if (stp) begin
                step_n++;
                if (ok || fall_c == 0 || ((c - fall_c + 1) % STEP) != 0) step_bad++;
            end
            if (act !== !ok) inv_bad++;
            prev = ok;
            req = (c < w) || (c + 1 >= p2s && c + 1 < p2s + p2l);
        end
        req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miss++;
            vectors++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    end

    initial begin
        int fc, rc, fl, dnn, dc, sn, sb, ib;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 ok in reset", ok, 1);
        chk("R1 active in reset", act, 0);
        chk("R1 step in reset", stp, 0);
        chk("R1 done in reset", dn, 0);
        rst_n = 1'b1;
        idle(3);
        chk("R1 ok after reset", ok, 1);
        chk("R1 done after reset", dn, 0);

        // R2 R3 R4 R5 R6 R9: sweep of pulse widths
        for (int w = 1; w <= 8; w++) begin
            observe(w, 0, 0, FALL + RUN + 6, fc, rc, fl, dnn, dc, sn, sb, ib);
            if (w >= MINW) begin
                chk($sformatf("R2 w=%0d runs", w), fl, 1);
                chk($sformatf("R3 w=%0d fall cycle", w), fc, FALL);
                chk($sformatf("R4 w=%0d rise cycle", w), rc, FALL + RUN);
                chk($sformatf("R5 w=%0d done count", w), dnn, 1);
                chk($sformatf("R5 w=%0d done cycle", w), dc, FALL + RUN);
                chk($sformatf("R9 w=%0d step count", w), sn, RUN / STEP);
                chk($sformatf("R9 w=%0d step placement", w), sb, 0);
            end else begin
                chk($sformatf("R2 w=%0d rejected", w), fl, 0);
                chk($sformatf("R2 w=%0d no done", w), dnn, 0);
                chk($sformatf("R2 w=%0d no step", w), sn, 0);
            end
            chk($sformatf("R6 w=%0d active inverse", w), ib, 0);
            idle(3);
        end

        // R7: second pulse inside the run is ignored
        observe(MINW, 15, 8, FALL + RUN + 20, fc, rc, fl, dnn, dc, sn, sb, ib);
        chk("R7 single run", fl, 1);
        chk("R7 run length", rc - fc, RUN);
        chk("R7 single done", dnn, 1);
        idle(3);

        // R8: request held past the end of the run
        observe(RUN + 25, 0, 0, FALL + RUN + 30, fc, rc, fl, dnn, dc, sn, sb, ib);
        chk("R8 held request single run", fl, 1);
        chk("R8 held request rise", rc, FALL + RUN);
        idle(3);
        observe(MINW, 0, 0, FALL + RUN + 6, fc, rc, fl, dnn, dc, sn, sb, ib);
        chk("R8 rearmed run", fl, 1);
        chk("R8 rearmed fall cycle", fc, FALL);
        chk("R8 rearmed rise cycle", rc, FALL + RUN);
        idle(3);

        // R1: reset during a run
        observe(MINW, 0, 0, FALL + 10, fc, rc, fl, dnn, dc, sn, sb, ib);
        chk("R1 busy before mid reset", ok, 0);
        rst_n = 1'b0;
        #2;
        chk("R1 ok after mid reset", ok, 1);
        chk("R1 active after mid reset", act, 0);
        chk("R1 done after mid reset", dn, 0);
        idle(2);
        rst_n = 1'b1;
        idle(3);
        observe(MINW, 0, 0, FALL + RUN + 6, fc, rc, fl, dnn, dc, sn, sb, ib);
        chk("R3 fall after mid reset", fc, FALL);
        chk("R4 rise after mid reset", rc, FALL + RUN);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end
endmodule